// File: doc/BRIEF.md
# Enumeration Center Multiply-Accumulator

This block produces the center value of one level of a lattice enumeration tree walk. It computes the negated dot product of the fixed coordinates above the level with one column of Gram–Schmidt coefficients. The arithmetic is signed fixed-point with 24 fractional bits. A job begins with a start pulse that gives the number of terms and, optionally, a seed partial sum. The seed lets coordinates that stay fixed near the top of the tree be folded in once instead of being summed again. After the start, coefficient/coordinate pairs stream in at up to one per cycle. Each pair runs through a register stage, a multiply stage and an accumulate stage.

When the last product has been accumulated, a one-cycle valid pulse marks the result. The result has three parts: the center as a 36-bit fixed-point word (12 integer bits, 24 fractional), its nearest integer, and a direction bit. The walk uses the direction bit to pick which way its first zig-zag step goes. Coefficient storage lives outside the block.

Top module: `ctr_mac`

## Requirements
- R1: The center output equals −(S0 + Σ x_k·μ_k) over the pairs of the job. μ_k is a signed coefficient with 24 fractional bits. x_k is a signed integer. The output is a two's complement word with 24 fractional bits.
- R2: When `seed_en_i` is high at an accepted start, S0 is `seed_i` (a signed value with 24 fractional bits). Otherwise S0 is zero and `seed_i` has no effect.
- R3: A job with zero terms and no seed yields center 0, integer 0 and direction 0.
- R4: `res_valid_o` is a one-cycle pulse. It rises exactly two clock edges after the edge that samples the job's final pair. For a job with zero terms, it rises two edges after the edge that samples the start. With a gapless stream of n pairs, it therefore rises n+2 edges after the start.
- R5: The integer output is floor(center + 1/2), a signed 12-bit value, so exact halves round upward (+0.5 → 1, −0.5 → 0).
- R6: The direction output is 1 exactly when the center is strictly below its rounded integer, and 0 otherwise.
- R7: A start that arrives while a job is still in flight has no effect. A job is in flight from its accepted start up to the edge on which its valid pulse rises. Such a start changes neither that job's result nor its timing, and it produces no extra result.
- R8: Only the first n pairs sampled after the accepting start edge are used. Pairs presented on the start edge itself, or while no job is counting pairs, are ignored.
- R9: Cycles with `op_valid_i` low inside a job are skipped without consuming a term.
- R10: After reset, `res_valid_o`, the center, the integer and the direction are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a job |
| n_terms_i | input | 7 | Number of pairs in the job (0 to 64) |
| seed_en_i | input | 1 | Use `seed_i` as the starting partial sum |
| seed_i | input | 48 | Seed partial sum, 24 fractional bits |
| op_valid_i | input | 1 | A pair is present this cycle |
| coef_i | input | 25 | Coefficient μ, sign-extended, 24 fractional bits |
| coord_i | input | 18 | Coordinate x, signed integer |
| res_valid_o | output | 1 | Result pulse |
| ctr_o | output | 36 | Center, 12 integer and 24 fractional bits |
| rnd_o | output | 12 | Center rounded to nearest, halves up |
| dir_o | output | 1 | 1 when center is below its rounded integer |

## Verification
The bench concentrates on the exact half-way centers +0.5 and −0.5. A design that rounded half away from zero or to even would return −1 or the wrong integer for these, and a design that tested the wrong fraction bit would get the direction wrong. It runs zero-term jobs, with and without a seed. A pipeline that waited for a product before flagging completion would hang or shift the latency there, and one that applied the sign before seeding would get the seeded result wrong. It also places stray pairs on and just before the start edge, inserts a gap mid-stream, and fires a second start during a busy job. A design that counted the wrong pairs, stalled badly on a gap or restarted mid-job would produce a wrong value, a wrong arrival cycle or an extra result.

// File: rtl/ctr_mac_pkg.sv
package ctr_mac_pkg;
   // Width of a counter able to hold the values 0..max_v.
   function automatic int cnt_width(input int max_v);
      int w;
      w = 1;
      while ((1 << w) <= max_v) w++;
      return w;
   endfunction
endpackage

// File: rtl/ctr_mac_issue.sv
module ctr_mac_issue #(
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [CNT_W-1:0] n_terms_i,
   input  logic             op_valid_i,
   input  logic             pipe_busy_i,
   output logic             load_o,
   output logic             take_o,
   output logic             last_o,
   output logic             busy_o
);
   logic [CNT_W-1:0] rem_q;
   logic             active_q;

   assign busy_o = active_q | pipe_busy_i;
   assign load_o = start_i & ~busy_o;
   assign take_o = active_q & op_valid_i;
   assign last_o = (load_o & (n_terms_i == '0)) | (take_o & (rem_q == CNT_W'(1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q    <= '0;
         active_q <= 1'b0;
      end else if (load_o) begin
         rem_q    <= n_terms_i;
         active_q <= (n_terms_i != '0);
      end else if (take_o) begin
         rem_q    <= rem_q - CNT_W'(1);
         active_q <= (rem_q != CNT_W'(1));
      end
   end

   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && busy_o && !take_o) |=> $stable(rem_q)); // R7
   AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
      active_q |-> (rem_q != '0)); // R8
endmodule

// File: rtl/ctr_mac_mul.sv
module ctr_mac_mul #(
   parameter int MU_W = 25,
   parameter int X_W  = 18,
   localparam int P_W = MU_W + X_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  take_i,
   input  logic                  last_i,
   input  logic signed [MU_W-1:0] coef_i,
   input  logic signed [X_W-1:0]  coord_i,
   output logic signed [P_W-1:0]  prod_o,
   output logic                  pv_o,
   output logic                  mark_o,
   output logic                  busy_o
);
   logic signed [MU_W-1:0] a_q;
   logic signed [X_W-1:0]  b_q;
   logic                   v1_q, m1_q, v2_q, m2_q;
   logic signed [P_W-1:0]  p_q;

   // stage 1: operand capture
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q  <= '0;
         b_q  <= '0;
         v1_q <= 1'b0;
         m1_q <= 1'b0;
      end else begin
         v1_q <= take_i;
         m1_q <= last_i;
         if (take_i) begin
            a_q <= coef_i;
            b_q <= coord_i;
         end
      end
   end

   // stage 2: product register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p_q  <= '0;
         v2_q <= 1'b0;
         m2_q <= 1'b0;
      end else begin
         v2_q <= v1_q;
         m2_q <= m1_q;
         if (v1_q) p_q <= a_q * b_q;
      end
   end

   assign prod_o = p_q;
   assign pv_o   = v2_q;
   assign mark_o = m2_q;
   assign busy_o = m1_q | m2_q;

   AST_PIPE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      v1_q |=> v2_q); // R4
endmodule

// File: rtl/ctr_mac_acc.sv
module ctr_mac_acc #(
   parameter int ACC_W   = 48,
   parameter int P_W     = 43,
   parameter bit SEED_EN = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    load_i,
   input  logic                    seed_en_i,
   input  logic signed [ACC_W-1:0] seed_i,
   input  logic                    pv_i,
   input  logic signed [P_W-1:0]   prod_i,
   input  logic                    mark_i,
   output logic signed [ACC_W-1:0] acc_o,
   output logic                    done_o
);
   logic signed [ACC_W-1:0] acc_q;
   logic signed [ACC_W-1:0] init_v;
   logic                    done_q;

   generate
      if (SEED_EN) begin : g_seed
         assign init_v = seed_en_i ? seed_i : '0;
      end else begin : g_zero
         assign init_v = '0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= mark_i;
         if (load_i)    acc_q <= init_v;
         else if (pv_i) acc_q <= acc_q + ACC_W'(prod_i);
      end
   end

   assign acc_o  = acc_q;
   assign done_o = done_q;

   AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !pv_i) |=> $stable(acc_q)); // R1
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q); // R4
endmodule

// File: rtl/ctr_mac_round.sv
module ctr_mac_round #(
   parameter int ACC_W  = 48,
   parameter int INT_W  = 12,
   parameter int FRAC_W = 24,
   localparam int C_W   = INT_W + FRAC_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    done_i,
   input  logic signed [ACC_W-1:0] acc_i,
   output logic signed [C_W-1:0]   ctr_o,
   output logic signed [INT_W-1:0] rnd_o,
   output logic                    dir_o
);
   logic signed [ACC_W-1:0] neg;
   logic signed [C_W:0]     biased;
   logic [ACC_W-C_W:0]      top_bits;

   assign neg      = -acc_i;
   assign ctr_o    = neg[C_W-1:0];
   assign biased   = $signed({neg[C_W-1], neg[C_W-1:0]})
                   + $signed({{(INT_W+1){1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}});
   assign rnd_o    = biased[C_W-1:FRAC_W];
   // fraction of one half or more means the rounded value lies above
   assign dir_o    = neg[FRAC_W-1];
   assign top_bits = neg[ACC_W-1:C_W-1];

   AST_CTR_FITS: assert property (@(posedge clk) disable iff (!rst_n)
      done_i |-> (top_bits == '0 || top_bits == '1)); // R1
   AST_RND_FITS: assert property (@(posedge clk) disable iff (!rst_n)
      done_i |-> (biased[C_W] == biased[C_W-1])); // R5
endmodule

// File: rtl/ctr_mac.sv
module ctr_mac
   import ctr_mac_pkg::*;
#(
   parameter int  MAX_TERMS = 64,
   parameter int  MU_W      = 25,
   parameter int  X_W       = 18,
   parameter int  ACC_W     = 48,
   parameter int  INT_W     = 12,
   parameter int  FRAC_W    = 24,
   parameter bit  SEED_EN   = 1'b1,
   localparam int CNT_W     = cnt_width(MAX_TERMS),
   localparam int P_W       = MU_W + X_W,
   localparam int C_W       = INT_W + FRAC_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start_i,
   input  logic [CNT_W-1:0]        n_terms_i,
   input  logic                    seed_en_i,
   input  logic signed [ACC_W-1:0] seed_i,
   input  logic                    op_valid_i,
   input  logic signed [MU_W-1:0]  coef_i,
   input  logic signed [X_W-1:0]   coord_i,
   output logic                    res_valid_o,
   output logic signed [C_W-1:0]   ctr_o,
   output logic signed [INT_W-1:0] rnd_o,
   output logic                    dir_o
);
   generate
      if (ACC_W <= P_W) begin : g_bad_acc
         $error("accumulator must be wider than one product");
      end
      if (C_W > ACC_W) begin : g_bad_ctr
         $error("center word wider than accumulator");
      end
      if (MU_W <= FRAC_W) begin : g_bad_mu
         $error("coefficient needs a sign bit above the fraction");
      end
      if (MAX_TERMS < 1) begin : g_bad_terms
         $error("at least one term required");
      end
   endgenerate

   logic                    load, take, last, busy, pipe_busy;
   logic signed [P_W-1:0]   prod;
   logic                    pv, mark;
   logic signed [ACC_W-1:0] acc;

   ctr_mac_issue #(.CNT_W(CNT_W)) u_issue (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .n_terms_i(n_terms_i),
      .op_valid_i(op_valid_i), .pipe_busy_i(pipe_busy),
      .load_o(load), .take_o(take), .last_o(last), .busy_o(busy)
   );

   ctr_mac_mul #(.MU_W(MU_W), .X_W(X_W)) u_mul (
      .clk(clk), .rst_n(rst_n), .take_i(take), .last_i(last),
      .coef_i(coef_i), .coord_i(coord_i),
      .prod_o(prod), .pv_o(pv), .mark_o(mark), .busy_o(pipe_busy)
   );

   ctr_mac_acc #(.ACC_W(ACC_W), .P_W(P_W), .SEED_EN(SEED_EN)) u_acc (
      .clk(clk), .rst_n(rst_n), .load_i(load), .seed_en_i(seed_en_i),
      .seed_i(seed_i), .pv_i(pv), .prod_i(prod), .mark_i(mark),
      .acc_o(acc), .done_o(res_valid_o)
   );

   ctr_mac_round #(.ACC_W(ACC_W), .INT_W(INT_W), .FRAC_W(FRAC_W)) u_round (
      .clk(clk), .rst_n(rst_n), .done_i(res_valid_o), .acc_i(acc),
      .ctr_o(ctr_o), .rnd_o(rnd_o), .dir_o(dir_o)
   );

   AST_BUSY_BLOCKS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && busy) |-> !load); // R7
endmodule

// File: tb/ctr_mac_bench.sv
module ctr_mac_bench;
   localparam int CLK_PERIOD = 10;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               start = 1'b0;
   logic [6:0]         n_terms = '0;
   logic               seed_en = 1'b0;
   logic signed [47:0] seed = '0;
   logic               op_valid = 1'b0;
   logic signed [24:0] coef = '0;
   logic signed [17:0] coord = '0;
   logic               res_valid;
   logic signed [35:0] ctr;
   logic signed [11:0] rnd;
   logic               dir;

   int  cyc = 0;
   int  nchk = 0;
   int  nfail = 0;
   bit  finished = 1'b0;

   typedef struct {
      longint c;
      longint r;
      bit     d;
      int     t;
   } exp_t;
   exp_t q[$];

   logic signed [24:0] mu_a[8];
   logic signed [17:0] x_a[8];

   always #(CLK_PERIOD/2) clk = ~clk;
   always_ff @(posedge clk) cyc <= cyc + 1;

   ctr_mac u_ctr_mac (
      .clk(clk), .rst_n(rst_n), .start_i(start), .n_terms_i(n_terms),
      .seed_en_i(seed_en), .seed_i(seed), .op_valid_i(op_valid),
      .coef_i(coef), .coord_i(coord), .res_valid_o(res_valid),
      .ctr_o(ctr), .rnd_o(rnd), .dir_o(dir)
   );

   task automatic chk(input string req, input string what, input longint act, input longint expv);
      nchk++;
      if (act !== expv) begin
         nfail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   // monitor: pops the scoreboard on every result pulse
   always @(posedge clk) begin
      #1;
      if (rst_n && res_valid) begin
         if (q.size() == 0) begin
            chk("R7", "unexpected result pulse", 1, 0);
         end else begin
            exp_t e;
            e = q.pop_front();
            chk("R1", "center", longint'(ctr), e.c);
            chk("R5", "rounded integer", longint'(rnd), e.r);
            chk("R6", "direction", longint'(dir), longint'(e.d));
            chk("R4", "arrival edge", longint'(cyc), longint'(e.t));
         end
      end
   end

   // driver: runs one job and pushes the expected result
   task automatic do_job(input bit sen, input longint sd, input int n,
                         input int gap_at, input int poke_at, input bit stray);
      longint s;
      exp_t   e;
      int     last;
      s = sen ? sd : 0;
      for (int k = 0; k < n; k++) s += longint'(x_a[k]) * longint'(mu_a[k]);
      e.c = -s;
      e.r = (e.c + (longint'(1) <<< 23)) >>> 24;
      e.d = (e.c < (e.r <<< 24));
      if (stray) begin
         @(negedge clk);
         op_valid = 1'b1; coef = 25'sh123456; coord = 18'sd77;
      end
      @(negedge clk);
      start = 1'b1; seed_en = sen; seed = 48'(sd); n_terms = 7'(n);
      @(negedge clk);
      start = 1'b0; op_valid = 1'b0; seed = 48'sd31415; seed_en = 1'b1;
      last = cyc;
      for (int k = 0; k < n; k++) begin
         if (k == gap_at) @(negedge clk);
         op_valid = 1'b1; coef = mu_a[k]; coord = x_a[k];
         if (k == poke_at) begin
            start = 1'b1; n_terms = 7'd0; seed = 48'sd999999;
         end
         @(negedge clk);
         last = cyc;
         op_valid = 1'b0; start = 1'b0;
      end
      e.t = last + 2;
      q.push_back(e);
      repeat (5) @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      if (!finished) begin
         nchk++; nfail++;
         $display("FAIL R4 watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", nchk - nfail, nchk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R10", "reset valid", longint'(res_valid), 0);
      chk("R10", "reset center", longint'(ctr), 0);
      chk("R10", "reset integer", longint'(rnd), 0);
      chk("R10", "reset direction", longint'(dir), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R3: empty job, no seed
      do_job(1'b0, 0, 0, -1, -1, 1'b0);

      // R1: gapless three terms
      mu_a[0] = 25'sh400000; x_a[0] = 18'sd3;
      mu_a[1] = 25'sh200000; x_a[1] = -18'sd2;
      mu_a[2] = -25'sh100000; x_a[2] = 18'sd5;
      do_job(1'b0, 0, 3, -1, -1, 1'b0);

      // R5 R6: center exactly +0.5
      mu_a[0] = -25'sh800000; x_a[0] = 18'sd1;
      do_job(1'b0, 0, 1, -1, -1, 1'b0);

      // R5 R6: center exactly -0.5
      mu_a[0] = -25'sh800000; x_a[0] = -18'sd1;
      do_job(1'b0, 0, 1, -1, -1, 1'b0);

      // R2 R9: seeded, gap before second pair
      mu_a[0] = 25'sh0abcde; x_a[0] = -18'sd9;
      mu_a[1] = -25'sh333333; x_a[1] = 18'sd14;
      do_job(1'b1, (longint'(100) <<< 24) + 123, 2, 1, -1, 1'b0);

      // R2: seeded, no terms
      do_job(1'b1, -(longint'(37) <<< 24) - 5000, 0, -1, -1, 1'b0);

      // R1: five terms, large values
      mu_a[0] = 25'sh7fffff; x_a[0] = 18'sd2000;
      mu_a[1] = 25'sh7fffff; x_a[1] = -18'sd1999;
      mu_a[2] = -25'sh012345; x_a[2] = 18'sd300;
      mu_a[3] = 25'sh654321; x_a[3] = -18'sd11;
      mu_a[4] = -25'sh7fffff; x_a[4] = -18'sd6;
      do_job(1'b0, 0, 5, -1, -1, 1'b0);

      // R7: second start during a busy job
      mu_a[0] = 25'sh111111; x_a[0] = 18'sd4;
      mu_a[1] = -25'sh222222; x_a[1] = 18'sd7;
      mu_a[2] = 25'sh050505; x_a[2] = -18'sd3;
      mu_a[3] = 25'sh000001; x_a[3] = 18'sd1;
      do_job(1'b0, 0, 4, -1, 2, 1'b0);

      // R8: stray pairs before and on the start edge
      mu_a[0] = 25'sh180000; x_a[0] = 18'sd2;
      mu_a[1] = -25'sh0c0000; x_a[1] = 18'sd1;
      do_job(1'b1, longint'(5) <<< 24, 2, -1, -1, 1'b1);

      // R2: seed value present but not enabled
      mu_a[0] = 25'sh300000; x_a[0] = -18'sd6;
      do_job(1'b0, longint'(77) <<< 24, 1, -1, -1, 1'b0);

      repeat (6) @(negedge clk);
      chk("R7", "results left pending", longint'(q.size()), 0);
      finished = 1'b1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end
endmodule